// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block is a clocked model of the control side of a byte-wide parallel EEPROM. The chip-select, output-enable and write-enable pins are asynchronous to the system clock. Each of them passes through a two-flop synchronizer. The synchronized levels gate reads, drive a tri-state enable for the data bus, and qualify write strobes. Byte loads that land in one page collect in a page buffer. They are committed to a small on-chip byte array once the internal programming cycle ends.

A write strobe is the interval in which chip select and write enable are both low while output enable is high. The address is taken when the strobe starts and the data when it ends. A strobe shorter than a minimum number of clocks is discarded. Programming starts on its own once no new accepted load has begun within a gap window. During programming, reads return a status byte instead of array data. Bit 7 of that byte is the complement of bit 7 of the last byte loaded, and bit 6 alternates from one read to the next. All timing limits are parameters counted in clock cycles.

The controller is a three-state machine:
- ST_IDLE: no page open. The first accepted load opens a page and takes the transition LOAD_OPEN to ST_LOAD.
- ST_LOAD: more loads to the same page are collected. The transition GAP_EXPIRE to ST_PROG is taken once GAP_CYC cycles have passed since the start of the last accepted load's strobe, with no strobe active.
- ST_PROG: the machine stays here for PROG_CYC cycles. The transition PROG_DONE then commits the buffer and returns to ST_IDLE.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: `dq_oe` is 1 only while both synchronized chip select and output enable are low. `dq_out` is 0 whenever `dq_oe` is 0. Outside ST_PROG, a read returns the array byte at `addr`. After reset every array byte reads 0xFF.
- R2: A strobe made with output enable low loads nothing, even when chip select and write enable are both low.
- R3: The byte address is captured when the write strobe starts. The data byte is captured when the strobe ends. An address or data change in mid-strobe therefore writes the final data to the first address.
- R4: A write strobe lasting fewer than MIN_PW synchronized clocks is discarded. It opens no page and starts no programming.
- R5: All bytes loaded into one page are written to the array together at the end of the programming cycle.
- R6: While a page is open, a load whose address bits above the low OFFS_W bits differ from the open page is ignored.
- R7: A load whose strobe starts fewer than GAP_CYC cycles after the start of the previous accepted load joins the same page.
- R8: In ST_PROG, read bit 7 is the complement of bit 7 of the last accepted byte, and bits 5..0 equal that byte's bits 5..0.
- R9: In ST_PROG, read bit 6 is 0 on the first read of the programming cycle and inverts after each completed read.
- R10: ST_PROG lasts exactly PROG_CYC cycles. Write strobes during it are ignored. Afterwards, reads return the true stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address; the top ADDR_W-OFFS_W bits select the page |
| dq_in | input | 8 | Data bus input |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus drive enable; 0 means high impedance |

## Verification
A wrong state or a wrong latched page shows at the ports on the first read once programming has started. That read returns array data where a status byte was due, or a status byte where data was due. A lost or misdirected byte load shows as 0xFF, or as the wrong byte, on the first read after PROG_CYC cycles. A wrong gap or program count shifts the point at which reads switch between status and data. The directed scenarios read just inside and just beyond those windows, so the fault appears within one read.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } ee_state_t;
endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_in,
    output logic [N-1:0] pins_s
);
    logic [N-1:0] stage1;

    for (genvar g = 0; g < N; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= 1'b1;
                pins_s[g] <= 1'b1;
            end else begin
                stage1[g] <= pins_in[g];
                pins_s[g] <= stage1[g];
            end
        end
    end
endmodule

// File: rtl/eeprom_strobe_det.sv
module eeprom_strobe_det #(
    parameter int MIN_PW  = 3,
    parameter int GAP_CYC = 300,
    localparam int PW_W   = $clog2(MIN_PW + 1),
    localparam int GAP_W  = $clog2(GAP_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_act,
    output logic             str_start,
    output logic             str_ok,
    output logic [GAP_W-1:0] since_start
);
    logic            wr_q;
    logic [PW_W-1:0] pw_cnt;

    assign str_start = wr_act && !wr_q;
    assign str_ok    = !wr_act && wr_q && (pw_cnt >= PW_W'(MIN_PW));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q        <= 1'b0;
            pw_cnt      <= '0;
            since_start <= GAP_W'(GAP_CYC);
        end else begin
            wr_q <= wr_act;
            if (str_start) begin
                pw_cnt <= PW_W'(1);
            end else if (wr_act && pw_cnt < PW_W'(MIN_PW)) begin
                pw_cnt <= pw_cnt + 1'b1;
            end
            if (str_start) begin
                since_start <= GAP_W'(1);
            end else if (since_start < GAP_W'(GAP_CYC)) begin
                since_start <= since_start + 1'b1;
            end
        end
    end
endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store #(
    parameter int ADDR_W     = 9,
    parameter int OFFS_W     = 7,
    localparam int PAGE_W    = ADDR_W - OFFS_W,
    localparam int DEPTH     = 1 << ADDR_W,
    localparam int PAGE_SIZE = 1 << OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [OFFS_W-1:0] ld_offs,
    input  logic [7:0]        ld_data,
    input  logic              commit,
    input  logic [PAGE_W-1:0] commit_page,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0]           mem  [DEPTH];
    logic [7:0]           pbuf [PAGE_SIZE];
    logic [PAGE_SIZE-1:0] pvalid;

    always_ff @(posedge clk) begin
        if (ld_en) begin
            pbuf[ld_offs] <= ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pvalid <= '0;
        end else if (commit) begin
            pvalid <= '0;
        end else if (ld_en) begin
            pvalid[ld_offs] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (commit) begin
            for (int j = 0; j < PAGE_SIZE; j++) begin
                if (pvalid[j]) begin
                    mem[{commit_page, OFFS_W'(j)}] <= pbuf[j];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
    import eeprom_page_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int OFFS_W   = 7,
    parameter int GAP_CYC  = 300,
    parameter int PROG_CYC = 1000,
    parameter int MIN_PW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam int GAP_W  = $clog2(GAP_CYC + 1);
    localparam int PROG_W = $clog2(PROG_CYC + 1);

    ee_state_t state_q, state_n;

    logic [2:0]        pin_s;
    logic              ce_s, oe_s, we_s;
    logic              rd_act, rd_q, rd_fall, wr_act;
    logic              str_start, str_ok;
    logic [GAP_W-1:0]  since_start, gap_cnt;
    logic [PROG_W-1:0] prog_cnt;
    logic [ADDR_W-1:0] lat_addr;
    logic [PAGE_W-1:0] cur_page;
    logic [7:0]        last_data, rd_data;
    logic              page_hit, buf_wr, gap_done, prog_done, toggle_q;

    eeprom_pin_sync #(.N(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in ({we_n, oe_n, ce_n}),
        .pins_s  (pin_s)
    );

    assign ce_s = pin_s[0];
    assign oe_s = pin_s[1];
    assign we_s = pin_s[2];

    assign rd_act  = !ce_s && !oe_s;
    assign wr_act  = !ce_s && !we_s && oe_s;
    assign rd_fall = rd_q && !rd_act;

    eeprom_strobe_det #(.MIN_PW(MIN_PW), .GAP_CYC(GAP_CYC)) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_act      (wr_act),
        .str_start   (str_start),
        .str_ok      (str_ok),
        .since_start (since_start)
    );

    assign page_hit  = lat_addr[ADDR_W-1:OFFS_W] == cur_page;
    assign buf_wr    = str_ok && ((state_q == ST_IDLE) ||
                                  (state_q == ST_LOAD && page_hit));
    assign gap_done  = (gap_cnt >= GAP_W'(GAP_CYC)) && !wr_act;
    assign prog_done = (state_q == ST_PROG) && (prog_cnt == PROG_W'(PROG_CYC - 1));

    eeprom_page_store #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_en       (buf_wr),
        .ld_offs     (lat_addr[OFFS_W-1:0]),
        .ld_data     (dq_in),
        .commit      (prog_done),
        .commit_page (cur_page),
        .rd_addr     (addr),
        .rd_data     (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (buf_wr)                state_n = ST_LOAD;
            ST_LOAD: if (!buf_wr && gap_done)   state_n = ST_PROG;
            ST_PROG: if (prog_done)             state_n = ST_IDLE;
            default:                            state_n = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            lat_addr  <= '0;
            cur_page  <= '0;
            last_data <= '0;
            gap_cnt   <= '0;
            prog_cnt  <= '0;
            toggle_q  <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (str_start) begin
                lat_addr <= addr;
            end
            if (buf_wr) begin
                last_data <= dq_in;
                if (state_q == ST_IDLE) begin
                    cur_page <= lat_addr[ADDR_W-1:OFFS_W];
                end
            end
            if (buf_wr) begin
                gap_cnt <= since_start;
            end else if (gap_cnt < GAP_W'(GAP_CYC)) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
            if (state_q == ST_PROG) begin
                prog_cnt <= prog_cnt + 1'b1;
            end else begin
                prog_cnt <= '0;
            end
            if (state_q != ST_PROG) begin
                toggle_q <= 1'b0;
            end else if (rd_fall) begin
                toggle_q <= !toggle_q;
            end
        end
    end

    // outputs
    always_comb begin
        dq_oe  = rd_act;
        dq_out = 8'h00;
        if (rd_act) begin
            if (state_q == ST_PROG) begin
                dq_out = {!last_data[7], toggle_q, last_data[5:0]};
            end else begin
                dq_out = rd_data;
            end
        end
    end
endmodule

// File: rtl/eeprom_page_ctrl_chk.sv
module eeprom_page_ctrl_chk
    import eeprom_page_pkg::*;
#(
    parameter int PAGE_W   = 2,
    parameter int PROG_CYC = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [7:0]        dq_out,
    input ee_state_t         state,
    input logic              buf_wr,
    input logic [PAGE_W-1:0] ld_page,
    input logic [PAGE_W-1:0] cur_page,
    input logic [7:0]        last_data
);
    int unsigned pc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= 0;
        end else if (state == ST_PROG) begin
            pc <= pc + 1;
        end else begin
            pc <= 0;
        end
    end

    p_bus_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!$past(ce_n, 2) && !$past(oe_n, 2)));

    p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> dq_out == 8'h00);

    p_page_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && state == ST_LOAD) |-> ld_page == cur_page);

    p_poll_bit7_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && dq_oe) |-> dq_out[7] != last_data[7]);

    p_no_load_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |-> !buf_wr);

    p_prog_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && pc != PROG_CYC - 1) |=> state == ST_PROG);

    p_prog_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && pc == PROG_CYC - 1) |=> state == ST_IDLE);
endmodule

bind eeprom_page_ctrl eeprom_page_ctrl_chk #(
    .PAGE_W   (ADDR_W - OFFS_W),
    .PROG_CYC (PROG_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .state     (state_q),
    .buf_wr    (buf_wr),
    .ld_page   (lat_addr[ADDR_W-1:OFFS_W]),
    .cur_page  (cur_page),
    .last_data (last_data)
);

// File: tb/eeprom_page_ctrl_test.sv
module eeprom_page_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 9;
    localparam int OFFS_W     = 7;
    localparam int GAP_CYC    = 40;
    localparam int PROG_CYC   = 200;
    localparam int MIN_PW     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        dq_in = '0;
    logic [7:0]        dq_out;
    logic              dq_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = !clk;

    eeprom_page_ctrl #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .GAP_CYC(GAP_CYC),
        .PROG_CYC(PROG_CYC), .MIN_PW(MIN_PW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        idle(3);
        d = dq_out; oe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        idle(3);
    endtask

    task automatic read_check(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic       oe;
        do_read(a, d, oe);
        check(req, {7'd0, oe}, 8'h01);
        check(req, d, exp);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int low);
        @(negedge clk);
        addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(low);
        we_n = 1'b1; ce_n = 1'b1;
        idle(4);
    endtask

    // R1: reset state, bus float and erased array
    task automatic t_reset();
        idle(2);
        check("R1 idle oe", {7'd0, dq_oe}, 8'h00);
        check("R1 idle dout", dq_out, 8'h00);
        read_check("R1 erased", 9'h000, 8'hFF);
        read_check("R1 erased top", 9'h1FF, 8'hFF);
        check("R1 released oe", {7'd0, dq_oe}, 8'h00);
    endtask

    // R5 page load, R8 R9 status, R10 ignored writes and timing
    task automatic t_page();
        do_write(9'h010, 8'hA5, 4);
        do_write(9'h011, 8'h3C, 4);
        do_write(9'h07F, 8'h81, 4);
        idle(GAP_CYC + 10);
        read_check("R8 R9 status first", 9'h010, 8'h01);
        read_check("R9 status second", 9'h010, 8'h41);
        read_check("R9 status third", 9'h011, 8'h01);
        do_write(9'h012, 8'h55, 4);
        idle(PROG_CYC);
        read_check("R5 byte0", 9'h010, 8'hA5);
        read_check("R5 byte1", 9'h011, 8'h3C);
        read_check("R5 byte last", 9'h07F, 8'h81);
        read_check("R10 prog write ignored", 9'h012, 8'hFF);
    endtask

    // R6 mismatch ignored, R7 load within gap joins page
    task automatic t_mismatch();
        do_write(9'h101, 8'h33, 4);
        idle(20);
        do_write(9'h100, 8'h22, 4);
        do_write(9'h005, 8'h99, 4);
        idle(GAP_CYC + 5);
        read_check("R8 status inverted b7", 9'h100, 8'hA2);
        idle(PROG_CYC);
        read_check("R7 early byte joined", 9'h101, 8'h33);
        read_check("R7 late byte joined", 9'h100, 8'h22);
        read_check("R6 mismatch ignored", 9'h005, 8'hFF);
    endtask

    // R3 address at strobe start, data at strobe end
    task automatic t_latch();
        @(negedge clk);
        addr = 9'h020; dq_in = 8'h11; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(4);
        addr = 9'h030; dq_in = 8'h77;
        idle(2);
        we_n = 1'b1; ce_n = 1'b1;
        idle(4);
        idle(GAP_CYC + PROG_CYC + 10);
        read_check("R3 final data at first addr", 9'h020, 8'h77);
        read_check("R3 later addr untouched", 9'h030, 8'hFF);
    endtask

    // R4 short pulse, R2 output enable low blocks write
    task automatic t_blocked();
        do_write(9'h040, 8'h12, 1);
        read_check("R4 short pulse no page", 9'h040, 8'hFF);
        @(negedge clk);
        addr = 9'h041; dq_in = 8'h34; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        idle(5);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        idle(4);
        idle(GAP_CYC + 10);
        read_check("R4 short pulse no prog", 9'h040, 8'hFF);
        read_check("R2 oe low blocked", 9'h041, 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_page();
        t_mismatch();
        t_latch();
        t_blocked();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule